// File: doc/BRIEF.md
# MDIO Management Target Decoder

This block is the responding side of an MDIO management link. It watches the management clock and the management data line, as driven by a station manager, from inside a fast system clock domain. On every rising edge of the management clock it takes in one bit. After a run of 32 ones it decodes the next 16 bits as a command header. A read command makes it return one 16-bit word from a small register bank, most significant bit first. A write command is accepted and its data word is gathered, but the bank does not change. Nothing else a PHY does is part of the block, and neither is the tri-state pad.

The bank holds 32 words of 16 bits. Two of them are identity words with fixed nonzero values; all the rest read as zero. The block answers every PHY address it sees. The address is latched but never compared. It is meant as a stand-in management target for a PHY model or for bring-up logic, with the data returned on a plain output that the pad logic can use.

Top module: `mdio_mgmt_target`

## Requirements
- R1: An input bit counts as 1 only when `mdio_out_i` and `mdio_oe_i` are both high at the rising management clock edge. Otherwise it counts as 0, so 32 edges with data high but enable low do not form a preamble.
- R2: A command header is recognised only after 32 consecutive ones. With 31 ones in front of it, a header gets no response.
- R3: The header is the 16 bits after the preamble, first bit received in bit 15: start [15:14], opcode [13:12], PHY address [11:7], register address [6:2], turnaround [1:0]. A start code other than 01, or an opcode other than 01 (write) or 10 (read), leaves the block idle and `mdio_in_o` unchanged.
- R4: A read is accepted when turnaround bit 0 is 0, whether the turnaround bits are driven as 10 or left undriven (00). A write is accepted only with turnaround 10. Read turnarounds 01 and 11 get no response.
- R5: After an accepted read header, `mdio_in_o` presents the addressed word on the next 16 management clock rising edges, bit 15 first and bit 0 last.
- R6: `mdio_in_o` changes only on a rising management clock edge. It keeps its value while the management clock is held low or high.
- R7: Without a rising management clock edge, the decoder state does not advance, however many system clocks go by.
- R8: After reset, register 2 reads 0x0022, register 3 reads 0x161a, and every other register reads 0x0000.
- R9: A write command with valid turnaround leaves the addressed register unchanged, as a later read shows.
- R10: Every PHY address gets the same response.
- R11: After reset `mdio_in_o` is 0 and the decoder is idle. A header sent with no preamble after reset gets no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, samples all inputs |
| rst_ni | input | 1 | Active-low synchronous reset |
| mdc_i | input | 1 | Management clock from the station manager |
| mdio_out_i | input | 1 | Data level driven by the station manager |
| mdio_oe_i | input | 1 | Station manager drive enable for the data line |
| mdio_in_o | output | 1 | Data bit returned to the station manager |

## Verification
The assertions take for granted that the management clock is already synchronous to `clk_i`. They also assume each management clock level lasts at least one system clock, so that every rising edge is seen exactly once. The bench changes the management inputs only at the falling system clock edge and holds each level for a full system clock. This matches that assumption. The bench then sweeps all 32 register addresses, each with a different PHY address. It also covers every turnaround pattern, the malformed start and opcode values, and preambles that are one bit short or gated off by the enable.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } mdio_st_e;

   localparam logic [1:0] START_CODE = 2'b01;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] TA_WRITE   = 2'b10;

endpackage

// File: rtl/mdio_edge_detect.sv
module mdio_edge_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic rise_o
);

   logic lvl_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int ID0_IDX  = 2,
   parameter logic [DATA_W-1:0] ID0_VAL = 'h0022,
   parameter int ID1_IDX  = 3,
   parameter logic [DATA_W-1:0] ID1_VAL = 'h161a,
   parameter bit WRITABLE = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i
);

   localparam int NUM_REGS = 1 << ADDR_W;

   function automatic logic [DATA_W-1:0] init_word(input logic [ADDR_W-1:0] a);
      if (a == ADDR_W'(ID0_IDX))      return ID0_VAL;
      else if (a == ADDR_W'(ID1_IDX)) return ID1_VAL;
      else                            return '0;
   endfunction

   generate
      if (WRITABLE) begin : g_store
         logic [DATA_W-1:0] mem_q [NUM_REGS];

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= init_word(ADDR_W'(i));
            end else if (wr_en_i) begin
               mem_q[wr_addr_i] <= wr_data_i;
            end
         end

         assign rd_data_o = mem_q[rd_addr_i];
      end else begin : g_fixed
         logic unused_wr;
         assign unused_wr = ^{clk_i, rst_ni, wr_en_i, wr_addr_i, wr_data_i};
         assign rd_data_o = init_word(rd_addr_i);
      end
   endgenerate

endmodule

// File: rtl/mdio_frame_decoder.sv
module mdio_frame_decoder
   import mdio_tgt_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rise_i,
   input  logic              mdo_i,
   input  logic              moe_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              mdi_o
);

   localparam int HDR_W   = 6 + 2 * ADDR_W;
   localparam int SHIFT_W = HDR_W + DATA_W;
   localparam int CNT_W   = $clog2(SHIFT_W + 1) + 1;
   localparam int ST_HI   = HDR_W - 1;
   localparam int OP_HI   = HDR_W - 3;
   localparam int PHY_HI  = 2 * ADDR_W + 1;
   localparam int PHY_LO  = ADDR_W + 2;
   localparam int REG_HI  = ADDR_W + 1;
   localparam int REG_LO  = 2;

   localparam logic signed [CNT_W-1:0] C_LOAD = CNT_W'(SHIFT_W);
   localparam logic signed [CNT_W-1:0] C_HDR  = CNT_W'(DATA_W);
   localparam logic signed [CNT_W-1:0] C_ZERO = '0;
   localparam logic signed [CNT_W-1:0] C_ONE  = CNT_W'(1);
   localparam logic signed [CNT_W-1:0] C_NEG  = '1;

   logic [SHIFT_W-1:0]       sh_q, sh_n;
   logic signed [CNT_W-1:0]  cnt_q, cnt_v, cnt_n;
   mdio_st_e                 st_q, st_n;
   logic [ADDR_W-1:0]        phy_q, phy_n, reg_q, reg_n;
   logic [DATA_W-1:0]        obuf_q, obuf_n;
   logic                     di_q, di_n;
   logic                     wr_en;
   logic                     unused_phy;

   assign unused_phy = ^phy_q;

   always_comb begin
      sh_n   = {sh_q[SHIFT_W-2:0], mdo_i & moe_i};
      cnt_v  = cnt_q;
      st_n   = st_q;
      phy_n  = phy_q;
      reg_n  = reg_q;
      obuf_n = obuf_q;
      di_n   = di_q;
      wr_en  = 1'b0;
      if (rise_i) begin
         if (&sh_n) cnt_v = C_LOAD;
         if (cnt_v == C_HDR) begin
            if (sh_n[ST_HI -: 2] == START_CODE && sh_n[OP_HI -: 2] == OP_WRITE &&
                sh_n[1:0] == TA_WRITE)
               st_n = ST_WR;
            else if (sh_n[ST_HI -: 2] == START_CODE && sh_n[OP_HI -: 2] == OP_READ &&
                     !sh_n[0])
               st_n = ST_RD;
            else
               st_n = ST_IDLE;
            if (st_n != ST_IDLE) begin
               phy_n = sh_n[PHY_HI:PHY_LO];
               reg_n = sh_n[REG_HI:REG_LO];
            end
            if (st_n == ST_RD) obuf_n = rd_data_i;
         end
         if (cnt_v < C_HDR && st_n == ST_RD) begin
            di_n   = obuf_n[DATA_W-1];
            obuf_n = {obuf_n[DATA_W-2:0], 1'b0};
         end
         if (cnt_v == C_ZERO && st_n != ST_IDLE) begin
            wr_en = (st_n == ST_WR);
            st_n  = ST_IDLE;
         end
      end
      cnt_n = (rise_i && cnt_v != C_NEG) ? cnt_v - C_ONE : cnt_v;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         st_q   <= ST_IDLE;
         phy_q  <= '0;
         reg_q  <= '0;
         obuf_q <= '0;
         di_q   <= 1'b0;
      end else if (rise_i) begin
         sh_q   <= sh_n;
         cnt_q  <= cnt_n;
         st_q   <= st_n;
         phy_q  <= phy_n;
         reg_q  <= reg_n;
         obuf_q <= obuf_n;
         di_q   <= di_n;
      end
   end

   assign rd_addr_o = sh_n[REG_HI:REG_LO];
   assign wr_en_o   = wr_en;
   assign wr_addr_o = reg_q;
   assign wr_data_o = sh_n[DATA_W-1:0];
   assign mdi_o     = di_q;

   // R1: an edge with the drive enable low shifts in a zero
   p_gated_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_i && !moe_i) |=> (sh_q[0] == 1'b0));

   // R2: a full run of ones reloads the bit counter
   p_sync_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_i && (&{sh_q[SHIFT_W-2:0], mdo_i & moe_i})) |=> (cnt_q == C_LOAD - C_ONE));

   // R3: a read is entered only on a management clock edge
   p_read_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_q == ST_RD) |-> $past(rise_i));

   // R6: the returned bit holds between management clock edges
   p_di_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rise_i |=> $stable(mdi_o));

   // R7: state and counter stay frozen without an edge
   p_no_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rise_i |=> ($stable(st_q) && $stable(cnt_q) && $stable(sh_q)));

endmodule

// File: rtl/mdio_mgmt_target.sv
module mdio_mgmt_target #(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int ID0_IDX  = 2,
   parameter logic [DATA_W-1:0] ID0_VAL = 'h0022,
   parameter int ID1_IDX  = 3,
   parameter logic [DATA_W-1:0] ID1_VAL = 'h161a,
   parameter bit WRITABLE = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mdc_i,
   input  logic mdio_out_i,
   input  logic mdio_oe_i,
   output logic mdio_in_o
);

   localparam int NUM_REGS = 1 << ADDR_W;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 8)
         else $fatal(1, "ADDR_W out of range");
      assert (DATA_W >= 2)
         else $fatal(1, "DATA_W too small");
      assert (ID0_IDX < NUM_REGS && ID1_IDX < NUM_REGS && ID0_IDX != ID1_IDX)
         else $fatal(1, "identity register indices invalid");
   end

   logic              rise;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_en;

   mdio_edge_detect u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (mdc_i),
      .rise_o (rise)
   );

   mdio_frame_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise),
      .mdo_i     (mdio_out_i),
      .moe_i     (mdio_oe_i),
      .rd_addr_o (rd_addr),
      .rd_data_i (rd_data),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .mdi_o     (mdio_in_o)
   );

   mdio_reg_bank #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .ID0_IDX(ID0_IDX), .ID0_VAL(ID0_VAL),
      .ID1_IDX(ID1_IDX), .ID1_VAL(ID1_VAL),
      .WRITABLE(WRITABLE)
   ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data)
   );

   // R11: reset leaves the returned bit low
   p_reset_low_r11: assert property (@(posedge clk_i)
      !rst_ni |=> (mdio_in_o == 1'b0));

endmodule

// File: tb/mdio_mgmt_target_tb_top.sv
module mdio_mgmt_target_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mdc = 1'b0;
   logic mdo = 1'b0;
   logic moe = 1'b0;
   logic mdi;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   mdio_mgmt_target dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .mdc_i      (mdc),
      .mdio_out_i (mdo),
      .mdio_oe_i  (moe),
      .mdio_in_o  (mdi)
   );

   function automatic logic [15:0] exp_word(input int a);
      if (a == 2)      return 16'h0022;
      else if (a == 3) return 16'h161a;
      else             return 16'h0000;
   endfunction

   function automatic logic [15:0] hdr(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] phy, input logic [4:0] rg,
                                       input logic [1:0] ta);
      return {st, op, phy, rg, ta};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clk_bit(input logic d, input logic oe);
      @(negedge clk); mdc = 1'b0; mdo = d; moe = oe;
      @(negedge clk); mdc = 1'b1;
      @(negedge clk);
   endtask

   task automatic preamble(input int n);
      for (int i = 0; i < n; i++) clk_bit(1'b1, 1'b1);
   endtask

   task automatic send_hdr(input logic [15:0] h, input logic [15:0] oe);
      for (int i = 15; i >= 0; i--) clk_bit(h[i], oe[i]);
   endtask

   task automatic collect(output logic [15:0] w);
      for (int i = 15; i >= 0; i--) begin
         clk_bit(1'b0, 1'b0);
         w[i] = mdi;
      end
   endtask

   task automatic do_read(input logic [15:0] h, input logic [15:0] oe, output logic [15:0] w);
      preamble(32);
      send_hdr(h, oe);
      collect(w);
   endtask

   task automatic do_write(input logic [15:0] h, input logic [15:0] d);
      preamble(32);
      send_hdr(h, 16'hFFFF);
      for (int i = 15; i >= 0; i--) clk_bit(d[i], 1'b1);
   endtask

   initial begin
      logic [15:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset output", {15'd0, mdi}, 16'h0000);

      // R11: header with no preamble after reset
      send_hdr(hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b00), 16'hFFFC);
      collect(w);
      chk("R11 no preamble ignored", w, 16'h0000);

      // R5 R8 R10: every register, varying PHY address
      for (int a = 0; a < 32; a++) begin
         do_read(hdr(2'b01, 2'b10, 5'((a * 7 + 3) % 32), 5'(a), 2'b00), 16'hFFFC, w);
         chk($sformatf("R5 R8 R10 read reg %0d", a), w, exp_word(a));
      end

      // R2: one short of a full preamble
      preamble(31);
      send_hdr(hdr(2'b01, 2'b10, 5'd1, 5'd3, 2'b00), 16'hFFFC);
      collect(w);
      chk("R2 31-bit preamble ignored", w, 16'h0000);

      // R4: driven turnaround 10 on a read
      do_read(hdr(2'b01, 2'b10, 5'd4, 5'd3, 2'b10), 16'hFFFF, w);
      chk("R4 read ta 10", w, 16'h161a);
      do_read(hdr(2'b01, 2'b10, 5'd4, 5'd3, 2'b01), 16'hFFFF, w);
      chk("R4 read ta 01 rejected", w, 16'h0000);
      do_read(hdr(2'b01, 2'b10, 5'd4, 5'd3, 2'b11), 16'hFFFF, w);
      chk("R4 read ta 11 rejected", w, 16'h0000);

      // R3: bad start and opcode values
      do_read(hdr(2'b00, 2'b10, 5'd0, 5'd3, 2'b00), 16'hFFFC, w);
      chk("R3 start 00 rejected", w, 16'h0000);
      do_read(hdr(2'b11, 2'b10, 5'd0, 5'd3, 2'b00), 16'hFFFC, w);
      chk("R3 start 11 rejected", w, 16'h0000);
      do_read(hdr(2'b01, 2'b00, 5'd0, 5'd3, 2'b00), 16'hFFFC, w);
      chk("R3 opcode 00 rejected", w, 16'h0000);
      do_read(hdr(2'b01, 2'b11, 5'd0, 5'd3, 2'b00), 16'hFFFC, w);
      chk("R3 opcode 11 rejected", w, 16'h0000);

      // R1: preamble with data high but enable low
      for (int i = 0; i < 32; i++) clk_bit(1'b1, 1'b0);
      send_hdr(hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b00), 16'hFFFC);
      collect(w);
      chk("R1 gated preamble ignored", w, 16'h0000);

      // R9: writes do not alter the bank
      do_write(hdr(2'b01, 2'b01, 5'd0, 5'd2, 2'b10), 16'hBEEF);
      do_read(hdr(2'b01, 2'b10, 5'd0, 5'd2, 2'b00), 16'hFFFC, w);
      chk("R9 reg 2 after write", w, 16'h0022);
      do_write(hdr(2'b01, 2'b01, 5'd9, 5'd3, 2'b10), 16'hFFFF);
      do_read(hdr(2'b01, 2'b10, 5'd9, 5'd3, 2'b00), 16'hFFFC, w);
      chk("R9 reg 3 after write", w, 16'h161a);
      do_write(hdr(2'b01, 2'b01, 5'd1, 5'd10, 2'b10), 16'h1234);
      do_read(hdr(2'b01, 2'b10, 5'd1, 5'd10, 2'b00), 16'hFFFC, w);
      chk("R9 reg 10 after write", w, 16'h0000);

      // R4: write with wrong turnaround, then a normal read recovers
      do_write(hdr(2'b01, 2'b01, 5'd0, 5'd3, 2'b00), 16'h5555);
      do_read(hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b00), 16'hFFFC, w);
      chk("R4 read after bad-ta write", w, 16'h161a);

      // R6 R7: stop mid-read with output high, then hold the clock
      preamble(32);
      send_hdr(hdr(2'b01, 2'b10, 5'd0, 5'd2, 2'b00), 16'hFFFC);
      for (int i = 0; i < 15; i++) clk_bit(1'b0, 1'b0);
      chk("R5 bit 1 of reg 2", {15'd0, mdi}, 16'h0001);
      repeat (20) @(negedge clk);
      chk("R7 clock held high", {15'd0, mdi}, 16'h0001);
      mdc = 1'b0;
      repeat (20) @(negedge clk);
      chk("R6 clock held low", {15'd0, mdi}, 16'h0001);
      clk_bit(1'b0, 1'b0);
      chk("R5 last bit of reg 2", {15'd0, mdi}, 16'h0000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule